// File: doc/BRIEF.md
# Keyboard and Display Device-Register Controller

This block sits on the 16-bit memory bus of a small processor and holds the registers for one character-input device and one character-output device. Four word addresses at the top of the address space belong to it: the keyboard status word, the keyboard character word, the display status word and the display character word. Any bus access to one of these four addresses is taken by the block, and its memory-select output stays low for that access. For every other access, memory-select goes high. Read data for the processor's memory data register comes from this block's registers on an I/O read and from the memory read data otherwise.

A pulse on the key strobe loads a character and sets the keyboard ready flag. Until software reads the keyboard character word, further strobes are ignored. A store to the display character word sends the character out as a one-cycle valid pulse, but only while the display ready flag is set. The store then clears that flag until the display reports completion on its done input. Stores made while the flag is clear are dropped.

Each status word carries a software-writable interrupt enable in bit 14. An interrupt request is raised whenever a device's ready bit and its enable bit are both set.

Top module: `kbd_disp_io`

## Requirements
- R1: With the default base, the I/O addresses are 0xFE00 (keyboard status), 0xFE02 (keyboard character), 0xFE04 (display status) and 0xFE06 (display character). `mem_sel` is 0 for a read or write to any of them, 1 for a read or write to any other address, and 0 when neither `bus_rd` nor `bus_wr` is high.
- R2: While `bus_rd` is high, `mdr_data` is combinational. For an I/O address it is that register's image, and for any other address it equals `mem_rdata`. A status image has the ready flag in bit 15, the interrupt enable in bit 14 and zeros elsewhere. A character image has the character in bits [7:0] and zeros in bits [15:8].
- R3: A `key_strobe` cycle while keyboard ready is 0 stores `key_code`. From the next cycle, the keyboard character word reads that code and keyboard status bit 15 reads 1.
- R4: A `key_strobe` while keyboard ready is 1 is ignored. The stored character stays unchanged.
- R5: A read of the keyboard character word clears keyboard ready from the next cycle. A read of the keyboard status word leaves it unchanged.
- R6: A write to the display character word while display ready is 1 has three effects. In the next cycle, `disp_valid` is high for exactly one cycle with `disp_char` equal to `bus_wdata[7:0]`. Display ready is cleared. The display character word then reads the sent character.
- R7: A write to the display character word while display ready is 0 is discarded. No `disp_valid` pulse occurs, and the stored character is unchanged.
- R8: A `disp_done` cycle while display ready is 0, with no accepted display write in the same cycle, sets display ready from the next cycle.
- R9: A write to a status word changes only its enable, which takes `bus_wdata[14]`. A ready bit is never changed by a bus write.
- R10: `kbd_irq` is high exactly when keyboard ready and the keyboard enable are both 1. `disp_irq` follows the same rule for the display.
- R11: After reset, keyboard ready is 0, display ready is 1, both enables are 0, both characters are 0x00, and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Bus read cycle |
| bus_wr | input | 1 | Bus write cycle |
| bus_wdata | input | 16 | Bus write data |
| mem_rdata | input | 16 | Read data returned by memory |
| mdr_data | output | 16 | Data steered to the memory data register |
| mem_sel | output | 1 | Memory is the target of the current access |
| key_strobe | input | 1 | One cycle: a new character is present |
| key_code | input | 8 | Incoming character |
| disp_valid | output | 1 | One-cycle pulse: `disp_char` is to be shown |
| disp_char | output | 8 | Outgoing character |
| disp_done | input | 1 | Display has finished and can accept more |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `key_strobe` and `disp_done` are single-cycle events sampled at the clock edge. The bench drives every stimulus from tasks that raise exactly one of these inputs for one cycle, starting at a falling edge, so none of these situations arises. It sweeps every 8-bit code through both the keyboard and display paths, and sweeps a window of addresses around the I/O block for both reads and writes. Each result is predicted from the address and code arithmetic.

// File: rtl/kbd_disp_io.sv
module kbd_disp_io #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mdr_data,
  output logic              mem_sel,
  input  logic              key_strobe,
  input  logic [CHAR_W-1:0] key_code,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done,
  output logic              kbd_irq,
  output logic              disp_irq
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IE_BIT  = DATA_W - 2;
  localparam logic [ADDR_W-1:0] A_KSTAT = IO_BASE;
  localparam logic [ADDR_W-1:0] A_KCHAR = IO_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DSTAT = IO_BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DCHAR = IO_BASE + ADDR_W'(6);

  logic              kbd_rdy, kbd_ie, disp_rdy, disp_ie;
  logic [CHAR_W-1:0] kbd_char;

  wire access = bus_rd | bus_wr;
  wire hit_ks = bus_addr == A_KSTAT;
  wire hit_kc = bus_addr == A_KCHAR;
  wire hit_ds = bus_addr == A_DSTAT;
  wire hit_dc = bus_addr == A_DCHAR;
  wire io_hit = hit_ks | hit_kc | hit_ds | hit_dc;

  wire rd_kchar  = bus_rd & hit_kc;
  wire wr_kstat  = bus_wr & hit_ks;
  wire wr_dstat  = bus_wr & hit_ds;
  wire key_take  = key_strobe & ~kbd_rdy;
  wire disp_take = bus_wr & hit_dc & disp_rdy;

  wire unused_wdata = ^{bus_wdata[RDY_BIT], bus_wdata[IE_BIT-1:CHAR_W]};

  assign mem_sel  = access & ~io_hit;
  assign kbd_irq  = kbd_rdy & kbd_ie;
  assign disp_irq = disp_rdy & disp_ie;

  wire [DATA_W-1:0] kstat_img = {kbd_rdy, kbd_ie, {(DATA_W-2){1'b0}}};
  wire [DATA_W-1:0] dstat_img = {disp_rdy, disp_ie, {(DATA_W-2){1'b0}}};
  wire [DATA_W-1:0] kchar_img = {{(DATA_W-CHAR_W){1'b0}}, kbd_char};
  wire [DATA_W-1:0] dchar_img = {{(DATA_W-CHAR_W){1'b0}}, disp_char};

  always_comb begin
    mdr_data = mem_rdata;
    if (bus_rd) begin
      if (hit_ks)      mdr_data = kstat_img;
      else if (hit_kc) mdr_data = kchar_img;
      else if (hit_ds) mdr_data = dstat_img;
      else if (hit_dc) mdr_data = dchar_img;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kbd_rdy  <= 1'b0;
      kbd_ie   <= 1'b0;
      kbd_char <= '0;
    end else begin
      kbd_rdy <= key_take | (kbd_rdy & ~rd_kchar);
      if (key_take) kbd_char <= key_code;
      if (wr_kstat) kbd_ie <= bus_wdata[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_rdy   <= 1'b1;
      disp_ie    <= 1'b0;
      disp_char  <= '0;
      disp_valid <= 1'b0;
    end else begin
      disp_valid <= disp_take;
      if (disp_take) begin
        disp_rdy  <= 1'b0;
        disp_char <= bus_wdata[CHAR_W-1:0];
      end else if (disp_done) begin
        disp_rdy <= 1'b1;
      end
      if (wr_dstat) disp_ie <= bus_wdata[IE_BIT];
    end
  end
endmodule

module kbd_disp_io_chk #(
  parameter int ADDR_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              mem_sel,
  input logic              key_strobe,
  input logic              disp_valid,
  input logic              disp_done,
  input logic              kbd_rdy,
  input logic              disp_rdy,
  input logic [CHAR_W-1:0] kbd_char
);
  wire chk_io = (bus_addr == IO_BASE) || (bus_addr == IO_BASE + ADDR_W'(2)) ||
                (bus_addr == IO_BASE + ADDR_W'(4)) || (bus_addr == IO_BASE + ADDR_W'(6));
  wire chk_dwr = bus_wr && (bus_addr == IO_BASE + ADDR_W'(6));
  wire chk_krd = bus_rd && (bus_addr == IO_BASE + ADDR_W'(2));

  // R1
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && chk_io |-> !mem_sel);
  // R3
  key_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe && !kbd_rdy |=> kbd_rdy);
  // R4
  key_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe && kbd_rdy |=> $stable(kbd_char));
  // R5
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_krd && !key_strobe |=> !kbd_rdy);
  // R6
  disp_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_dwr && disp_rdy |=> disp_valid && !disp_rdy);
  // R6
  disp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);
  // R7
  disp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_dwr && !disp_rdy |=> !disp_valid);
  // R8
  disp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_done && !chk_dwr |=> disp_rdy);
endmodule

bind kbd_disp_io kbd_disp_io_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .IO_BASE(IO_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .mem_sel(mem_sel), .key_strobe(key_strobe), .disp_valid(disp_valid),
  .disp_done(disp_done), .kbd_rdy(kbd_rdy), .disp_rdy(disp_rdy), .kbd_char(kbd_char)
);

// File: tb/tb_kbd_disp_io.sv
module tb_kbd_disp_io;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0, mem_rdata = '0;
  logic [15:0] mdr_data;
  logic        mem_sel;
  logic        key_strobe = 1'b0;
  logic [7:0]  key_code = '0;
  logic        disp_valid;
  logic [7:0]  disp_char;
  logic        disp_done = 1'b0;
  logic        kbd_irq, disp_irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  localparam logic [15:0] KS = 16'hFE00, KC = 16'hFE02, DS = 16'hFE04, DC = 16'hFE06;

  kbd_disp_io dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v, output logic ms);
    bus_addr = a; mem_rdata = ~a; bus_rd = 1'b1;
    #1; v = mdr_data; ms = mem_sel;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, output logic ms);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1; ms = mem_sel;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    key_code = c; key_strobe = 1'b1;
    @(negedge clk); key_strobe = 1'b0;
  endtask

  task automatic done_pulse();
    disp_done = 1'b1;
    @(negedge clk); disp_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic ms;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 disp_valid", {15'd0, disp_valid}, 16'd0);
    chk("R11 irqs", {14'd0, kbd_irq, disp_irq}, 16'd0);
    chk("R1 idle mem_sel", {15'd0, mem_sel}, 16'd0);
    rd(KS, v, ms); chk("R11 kbd status", v, 16'h0000);
    rd(DS, v, ms); chk("R11 disp status", v, 16'h8000);
    rd(KC, v, ms); chk("R11 kbd char", v, 16'h0000);
    rd(DC, v, ms); chk("R11 disp char", v, 16'h0000);

    // R1 R2 address sweep
    for (int a = 16'hFDF0; a <= 16'hFE10; a++) begin
      logic io;
      io = (a == KS) || (a == KC) || (a == DS) || (a == DC);
      rd(16'(a), v, ms);
      chk("R1 rd mem_sel", {15'd0, ms}, {15'd0, !io});
      if (!io) chk("R2 mem passthru", v, ~16'(a));
      if (!io) begin
        wr(16'(a), 16'h1234, ms);
        chk("R1 wr mem_sel", {15'd0, ms}, 16'd1);
      end
    end
    wr(KS, 16'h0000, ms); chk("R1 io wr mem_sel", {15'd0, ms}, 16'd0);
    rd(DS, v, ms); chk("R9 disp ready kept", v, 16'h8000);

    // R3 R5 every key code
    for (int c = 0; c < 256; c++) begin
      key(8'(c));
      rd(KS, v, ms); chk("R3 kbd ready", v, 16'h8000);
      if (c == 5) begin rd(KS, v, ms); chk("R5 status read keeps", v, 16'h8000); end
      rd(KC, v, ms); chk("R3 kbd char", v, 16'(c));
      rd(KS, v, ms); chk("R5 ready cleared", v, 16'h0000);
    end

    // R4 lockout
    key(8'h41); key(8'h42);
    rd(KC, v, ms); chk("R4 lockout", v, 16'h0041);
    key(8'h43);
    rd(KC, v, ms); chk("R4 after reenable", v, 16'h0043);

    // R9 R10 keyboard enable
    wr(KS, 16'h4000, ms);
    rd(KS, v, ms); chk("R9 kbd ie set", v, 16'h4000);
    chk("R10 kbd irq idle", {15'd0, kbd_irq}, 16'd0);
    key(8'h07);
    chk("R10 kbd irq", {15'd0, kbd_irq}, 16'd1);
    rd(KS, v, ms); chk("R2 kbd status img", v, 16'hC000);
    wr(KS, 16'h8000, ms);
    rd(KS, v, ms); chk("R9 ready unwritable", v, 16'h8000);
    chk("R10 irq off", {15'd0, kbd_irq}, 16'd0);
    rd(KC, v, ms);
    wr(KS, 16'hFFFF, ms);
    rd(KS, v, ms); chk("R9 write no set", v, 16'h4000);
    wr(KS, 16'h0000, ms);

    // R6 R7 R8 display, every code
    wr(DS, 16'h4000, ms);
    chk("R10 disp irq", {15'd0, disp_irq}, 16'd1);
    for (int c = 0; c < 256; c++) begin
      wr(DC, {8'hA5, 8'(c)}, ms);
      chk("R6 valid", {15'd0, disp_valid}, 16'd1);
      chk("R6 char", {8'd0, disp_char}, 16'(c));
      rd(DS, v, ms);
      chk("R6 pulse one cycle", {15'd0, disp_valid}, 16'd0);
      chk("R6 ready cleared", v, 16'h4000);
      chk("R10 disp irq low", {15'd0, disp_irq}, 16'd0);
      wr(DC, 16'(8'(c) ^ 8'hFF), ms);
      chk("R7 no pulse", {15'd0, disp_valid}, 16'd0);
      rd(DC, v, ms); chk("R7 char kept", v, 16'(c));
      done_pulse();
      rd(DS, v, ms); chk("R8 ready back", v, 16'hC000);
    end
    wr(DS, 16'h0000, ms);
    rd(DS, v, ms); chk("R9 disp ie clear", v, 16'h8000);
    chk("R10 disp irq off", {15'd0, disp_irq}, 16'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule